// File: doc/BRIEF.md
# Six-Instruction Single-Cycle Execution Core

This block is a minimal single-cycle processor core. On every clock cycle it presents its program counter on an instruction fetch port, receives one 32-bit instruction word back in the same cycle, decodes it, and commits the result at the next rising edge. Two instruction formats are understood. The register form carries two source register fields, a destination field, a shift field and a function code. The immediate form carries two register fields and a 16-bit constant.

Six operations are executed: register add and subtract, and word and byte loads and stores. Loads and stores reach memory through a plain data port that carries an address, write data, per-byte write enables and read data. The read data is expected back combinationally, within the same cycle. Byte lanes are big-endian: byte offset 0 of a word is its most significant byte. Operands live in a 32 x 32-bit register file with two read ports and one write port. Register 0 is hard-wired to zero. Every other encoding leaves all state untouched.

Top module: `mx_core`

## Requirements
- R1: While `rst` is high, the program counter loads 0 and `imem_addr` shows it. After reset is released, `imem_addr` advances by exactly 4 at every rising clock edge, whatever instruction is executed.
- R2: Field layout is: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shift [10:6], function [5:0]. Opcode 0 with function 32 and shift 0 writes rs + rt (modulo 2^32) into register rd.
- R3: Opcode 0 with function 34 and shift 0 writes rs - rt (modulo 2^32) into register rd.
- R4: Any other encoding changes no register and no memory. This covers every opcode other than 0, 32, 35, 40 and 43, and opcode 0 with a function code other than 32 or 34 or with a nonzero shift field.
- R5: Register 0 always reads as zero. Any write aimed at it, whether from arithmetic or from a load, is discarded.
- R6: For opcodes 32, 35, 40 and 43, `dmem_addr` equals the contents of register rs plus the sign-extended 16-bit constant in bits [15:0]. Negative offsets are included.
- R7: Opcode 35 (word load) writes `dmem_rdata` into register rt.
- R8: Opcode 43 (word store) drives `dmem_be` = 4'b1111 and `dmem_wdata` = contents of register rt.
- R9: Opcode 32 (byte load) selects a byte of `dmem_rdata` by address bits [1:0]: 0 selects [31:24], 1 selects [23:16], 2 selects [15:8] and 3 selects [7:0]. The byte goes into the low 8 bits of rt, and its bit 7 is copied into the upper 24 bits.
- R10: Opcode 40 (byte store) drives a one-hot `dmem_be`: offset 0 gives bit 3, offset 1 gives bit 2, offset 2 gives bit 1 and offset 3 gives bit 0. `dmem_wdata` carries the low byte of rt replicated on all four lanes.
- R11: `dmem_be` is all zero for every instruction that is not a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being fetched (program counter) |
| imem_data | input | 32 | Instruction word returned for `imem_addr` in the same cycle |
| dmem_addr | output | 32 | Effective byte address of the current load or store |
| dmem_wdata | output | 32 | Store data, lane-replicated for byte stores |
| dmem_be | output | 4 | Byte write enables, bit 3 = most significant lane |
| dmem_rdata | input | 32 | Word read from the data memory at `dmem_addr`, same cycle |

## Verification
Add and subtract are swept over every ordered pair drawn from the operand set {0x7FFFFFFF, 0x80000000, 0xFFFFFFFF, 1}. Each result is stored and compared, so carry wrap, borrow wrap and a swapped operand order each give a distinct wrong value. Byte loads and stores visit all four byte offsets, with both a positive and a negative offset, against a word whose bytes alternate in sign. A wrong lane, a reversed byte order or zero extension in place of sign extension each show up at a different offset. Every undefined function code and every undefined opcode is then applied with a live destination field, and the target register is read back afterwards to prove that no write happened.

// File: rtl/mx_pkg.sv
package mx_pkg;
  localparam int ILEN = 32;

  localparam logic [5:0] OPC_REG  = 6'd0;
  localparam logic [5:0] OPC_LDB  = 6'd32;
  localparam logic [5:0] OPC_LDW  = 6'd35;
  localparam logic [5:0] OPC_STB  = 6'd40;
  localparam logic [5:0] OPC_STW  = 6'd43;
  localparam logic [5:0] FN_ADD   = 6'd32;
  localparam logic [5:0] FN_SUB   = 6'd34;

  typedef enum logic [2:0] {
    K_NOP, K_ADD, K_SUB, K_LDW, K_STW, K_LDB, K_STB
  } kind_e;

  typedef struct packed {
    kind_e       kind;
    logic [4:0]  rs;
    logic [4:0]  rt;
    logic [4:0]  rd;
    logic [15:0] imm;
  } dec_t;
endpackage

// File: rtl/mx_decode.sv
module mx_decode
  import mx_pkg::*;
(
  input  logic [ILEN-1:0] instr,
  output dec_t            dec
);
  logic [5:0] opc;
  logic [5:0] fn;
  logic [4:0] shf;

  assign opc = instr[31:26];
  assign fn  = instr[5:0];
  assign shf = instr[10:6];

  always_comb begin
    dec.rs   = instr[25:21];
    dec.rt   = instr[20:16];
    dec.rd   = instr[15:11];
    dec.imm  = instr[15:0];
    dec.kind = K_NOP;
    case (opc)
      OPC_REG: begin
        if (shf == 5'd0) begin
          if (fn == FN_ADD)      dec.kind = K_ADD;
          else if (fn == FN_SUB) dec.kind = K_SUB;
        end
      end
      OPC_LDW: dec.kind = K_LDW;
      OPC_STW: dec.kind = K_STW;
      OPC_LDB: dec.kind = K_LDB;
      OPC_STB: dec.kind = K_STB;
      default: dec.kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/mx_regfile.sv
module mx_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic [RAW-1:0] ra_a,
  input  logic [RAW-1:0] ra_b,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_a,
  input  logic [DW-1:0]  wr_d,
  output logic [DW-1:0]  rd_a,
  output logic [DW-1:0]  rd_b
);
  logic [DW-1:0] store_q [NREG];

  always_ff @(posedge clk) begin
    if (wr_en && (wr_a != '0)) begin
      store_q[wr_a] <= wr_d;
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : store_q[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : store_q[ra_b];
endmodule

// File: rtl/mx_lsu.sv
module mx_lsu
  import mx_pkg::*;
#(
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int OW = $clog2(NB)
) (
  input  kind_e          kind,
  input  logic [DW-1:0]  ea,
  input  logic [DW-1:0]  rt_val,
  input  logic [DW-1:0]  rdata,
  output logic [NB-1:0]  be,
  output logic [DW-1:0]  wdata,
  output logic [DW-1:0]  load_val
);
  logic [NB-1:0] lane_sel;
  logic [7:0]    lane_byte [NB];
  logic [7:0]    picked;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane_sel[g]  = (ea[OW-1:0] == OW'(NB - 1 - g));
    assign lane_byte[g] = rdata[8*g +: 8] & {8{lane_sel[g]}};
  end

  always_comb begin
    picked = '0;
    for (int i = 0; i < NB; i++) begin
      picked = picked | lane_byte[i];
    end
  end

  always_comb begin
    case (kind)
      K_STW:   be = '1;
      K_STB:   be = lane_sel;
      default: be = '0;
    endcase
  end

  assign wdata    = (kind == K_STB) ? {NB{rt_val[7:0]}} : rt_val;
  assign load_val = (kind == K_LDB) ? {{(DW-8){picked[7]}}, picked} : rdata;
endmodule

// File: rtl/mx_core.sv
module mx_core
  import mx_pkg::*;
#(
  parameter int DW = 32,
  parameter int NREG = 32,
  parameter logic [DW-1:0] RESET_PC = '0,
  localparam int RAW = $clog2(NREG),
  localparam int NB  = DW / 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DW-1:0]     imem_addr,
  input  logic [ILEN-1:0]   imem_data,
  output logic [DW-1:0]     dmem_addr,
  output logic [DW-1:0]     dmem_wdata,
  output logic [NB-1:0]     dmem_be,
  input  logic [DW-1:0]     dmem_rdata
);
  logic [DW-1:0] pc_q;
  dec_t          dec;
  logic [DW-1:0] rs_val, rt_val, imm_sx, ea, alu_res, load_val;
  logic          wb_en;
  logic [RAW-1:0] wb_addr;
  logic [DW-1:0] wb_data;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_q + DW'(NB);
  end
  assign imem_addr = pc_q;

  mx_decode u_dec (.instr(imem_data), .dec(dec));

  mx_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk  (clk),
    .ra_a (dec.rs[RAW-1:0]),
    .ra_b (dec.rt[RAW-1:0]),
    .wr_en(wb_en),
    .wr_a (wb_addr),
    .wr_d (wb_data),
    .rd_a (rs_val),
    .rd_b (rt_val)
  );

  assign imm_sx  = {{(DW-16){dec.imm[15]}}, dec.imm};
  assign ea      = rs_val + imm_sx;
  assign alu_res = (dec.kind == K_SUB) ? (rs_val - rt_val) : (rs_val + rt_val);

  mx_lsu #(.DW(DW)) u_lsu (
    .kind    (dec.kind),
    .ea      (ea),
    .rt_val  (rt_val),
    .rdata   (dmem_rdata),
    .be      (dmem_be),
    .wdata   (dmem_wdata),
    .load_val(load_val)
  );
  assign dmem_addr = ea;

  always_comb begin
    wb_en   = 1'b0;
    wb_addr = dec.rd[RAW-1:0];
    wb_data = alu_res;
    case (dec.kind)
      K_ADD, K_SUB: wb_en = 1'b1;
      K_LDW, K_LDB: begin
        wb_en   = 1'b1;
        wb_addr = dec.rt[RAW-1:0];
        wb_data = load_val;
      end
      default: wb_en = 1'b0;
    endcase
    if (rst) wb_en = 1'b0;
  end
endmodule

// File: rtl/mx_core_chk.sv
module mx_core_chk #(
  parameter int DW = 32,
  localparam int NB = DW / 8
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] pc,
  input logic [5:0]    opcode,
  input logic [4:0]    rs_field,
  input logic [NB-1:0] be,
  input logic [DW-1:0] rs_val
);
  p_pc_reset_r1: assert property (@(posedge clk) rst |=> (pc == '0));

  p_pc_step_r1: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (pc == $past(pc) + DW'(NB)));

  p_zero_read_r5: assert property (@(posedge clk) disable iff (rst)
    (rs_field == 5'd0) |-> (rs_val == '0));

  p_word_store_r8: assert property (@(posedge clk) disable iff (rst)
    (opcode == 6'd43) |-> (be == '1));

  p_byte_store_r10: assert property (@(posedge clk) disable iff (rst)
    (opcode == 6'd40) |-> ($countones(be) == 1));

  p_idle_port_r11: assert property (@(posedge clk) disable iff (rst)
    ((opcode != 6'd43) && (opcode != 6'd40)) |-> (be == '0));
endmodule

bind mx_core mx_core_chk #(.DW(DW)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .pc      (imem_addr),
  .opcode  (imem_data[31:26]),
  .rs_field(imem_data[25:21]),
  .be      (dmem_be),
  .rs_val  (rs_val)
);

// File: tb/mx_core_tb_top.sv
module mx_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic [3:0]  dmem_be;

  logic [31:0] mem  [64];
  logic [31:0] rf_m [32];
  logic [31:0] pc_m;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign dmem_rdata = mem[dmem_addr[7:2]];

  mx_core dut_i (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_be(dmem_be),
    .dmem_rdata(dmem_rdata)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] r_ins(input logic [5:0] fn, input logic [4:0] rs,
      input logic [4:0] rt, input logic [4:0] rd, input logic [4:0] sh);
    return {6'd0, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] i_ins(input logic [5:0] op, input logic [4:0] rs,
      input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  // Drives one instruction, checks the ports mid-cycle, then updates the model.
  task automatic step(input logic [31:0] ins, input string tag);
    logic [5:0]  op;
    logic [4:0]  rs, rt, rd, sh;
    logic [5:0]  fn;
    logic [31:0] ea, a, b, rdv, exp_wd;
    logic [3:0]  exp_be;
    logic [7:0]  by;
    int lane;
    bit is_add, is_sub, is_lw, is_sw, is_lb, is_sb;
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    sh = ins[10:6];  fn = ins[5:0];
    a  = rf_m[rs]; b = rf_m[rt];
    ea = a + {{16{ins[15]}}, ins[15:0]};
    is_add = (op == 0) && (sh == 0) && (fn == 32);
    is_sub = (op == 0) && (sh == 0) && (fn == 34);
    is_lw = (op == 35); is_sw = (op == 43); is_lb = (op == 32); is_sb = (op == 40);
    lane = 3 - int'(ea[1:0]);
    exp_be = is_sw ? 4'hF : (is_sb ? (4'b1000 >> ea[1:0]) : 4'h0);
    exp_wd = is_sb ? {4{b[7:0]}} : b;
    imem_data = ins;
    #2;
    chk("R1", "pc", imem_addr, pc_m);
    chk((is_sw || is_sb) ? tag : "R11", "byte enables", {28'd0, dmem_be}, {28'd0, exp_be});
    if (is_sw || is_sb || is_lw || is_lb) chk(tag, "address", dmem_addr, ea);
    if (is_sw || is_sb) chk(tag, "store data", dmem_wdata, exp_wd);
    @(posedge clk);
    #1;
    rdv = mem[ea[7:2]];
    by  = rdv[8*lane +: 8];
    if (is_add) rf_m[rd] = a + b;
    if (is_sub) rf_m[rd] = a - b;
    if (is_lw)  rf_m[rt] = rdv;
    if (is_lb)  rf_m[rt] = {{24{by[7]}}, by};
    if (is_sw)  mem[ea[7:2]] = b;
    if (is_sb)  mem[ea[7:2]][8*lane +: 8] = b[7:0];
    rf_m[0] = '0;
    pc_m = pc_m + 32'd4;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = (i * 32'h01030507) ^ 32'h5A5A0000;
    for (int i = 0; i < 32; i++) rf_m[i] = '0;
    mem[0] = 32'h7FFFFFFF; mem[1] = 32'h80000000; mem[2] = 32'hFFFFFFFF;
    mem[3] = 32'h00000001; mem[4] = 32'h00000080; mem[5] = 32'h12A07F80;
    pc_m = '0;
    imem_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset pc", imem_addr, 32'd0);
    rst = 1'b0;

    // R7: load six words, then store each back out
    for (int r = 1; r <= 6; r++) step(i_ins(6'd35, 5'd0, 5'(r), 16'(4 * (r - 1))), "R7");
    for (int r = 1; r <= 6; r++) step(i_ins(6'd43, 5'd0, 5'(r), 16'd160), "R7");

    // R2 / R3: all ordered operand pairs
    for (int x = 1; x <= 4; x++) begin
      for (int y = 1; y <= 4; y++) begin
        step(r_ins(6'd32, 5'(x), 5'(y), 5'd10, 5'd0), "R2");
        step(i_ins(6'd43, 5'd0, 5'd10, 16'd200), "R2");
        step(r_ins(6'd34, 5'(x), 5'(y), 5'd10, 5'd0), "R3");
        step(i_ins(6'd43, 5'd0, 5'd10, 16'd200), "R3");
      end
    end

    // R5: register 0 stays zero
    step(r_ins(6'd32, 5'd1, 5'd2, 5'd0, 5'd0), "R5");
    step(i_ins(6'd43, 5'd0, 5'd0, 16'd204), "R5");
    step(i_ins(6'd35, 5'd0, 5'd0, 16'd8), "R5");
    step(i_ins(6'd43, 5'd0, 5'd0, 16'd204), "R5");
    step(r_ins(6'd32, 5'd0, 5'd2, 5'd12, 5'd0), "R5");
    step(i_ins(6'd43, 5'd0, 5'd12, 16'd204), "R5");

    // R9 / R6: byte loads at each offset, positive and negative constants
    for (int k = 0; k < 4; k++) begin
      step(i_ins(6'd32, 5'd0, 5'd7, 16'(20 + k)), "R9");
      step(i_ins(6'd43, 5'd0, 5'd7, 16'd208), "R9");
      step(i_ins(6'd32, 5'd5, 5'd8, 16'(-108 + k)), "R6");
      step(i_ins(6'd43, 5'd0, 5'd8, 16'd212), "R6");
    end

    // R10: byte stores at each offset, two source patterns
    for (int k = 0; k < 4; k++) begin
      step(i_ins(6'd40, 5'd0, 5'd6, 16'(64 + k)), "R10");
      step(i_ins(6'd40, 5'd5, 5'd1, 16'(-60 + k)), "R10");
    end

    // R6 / R8: word store and load through a negative offset
    step(i_ins(6'd43, 5'd5, 5'd1, 16'hFFFC), "R8");
    step(i_ins(6'd35, 5'd5, 5'd13, 16'hFFFC), "R6");
    step(i_ins(6'd43, 5'd0, 5'd13, 16'd216), "R6");

    // R4: undefined function codes and a nonzero shift field
    step(i_ins(6'd35, 5'd0, 5'd11, 16'd12), "R7");
    for (int f = 0; f < 64; f++) begin
      if (f != 32 && f != 34) step(r_ins(6'(f), 5'd1, 5'd2, 5'd11, 5'd0), "R4");
    end
    step(r_ins(6'd32, 5'd1, 5'd2, 5'd11, 5'd3), "R4");
    step(r_ins(6'd34, 5'd1, 5'd2, 5'd11, 5'd1), "R4");
    step(i_ins(6'd43, 5'd0, 5'd11, 16'd220), "R4");

    // R4: undefined opcodes aimed at r11
    for (int o = 1; o < 64; o++) begin
      if (o != 32 && o != 35 && o != 40 && o != 43)
        step(i_ins(6'(o), 5'd1, 5'd11, 16'h0010), "R4");
    end
    step(i_ins(6'd43, 5'd0, 5'd11, 16'd220), "R4");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule